// File: doc/BRIEF.md
# Successive-Approximation Conversion Controller with Result Coding

This block sequences a 12-bit successive-approximation search. On a start request it latches two mode bits. It then drives a trial code to an external capacitive DAC, one bit decision per conversion clock. Each decision comes from a comparator bit returned by the analog side. When the last bit is settled, the block emits a single-cycle completion pulse and presents the coded result.

The two mode bits choose how the result is coded. With the single-ended bit set, the input is measured against ground and the result is always straight binary; the bipolar bit is then ignored. A differential input in unipolar coding spans zero to full scale, and a negative difference resolves to code zero. A differential input in bipolar coding spans plus or minus half of full scale and is reported in two's complement. In bipolar coding the DAC is told, through a separate output, that each trial code stands for a level offset by half scale. The raw search therefore yields offset binary, and the controller turns that into two's complement by flipping the most significant bit.

Sampling, the capacitor array and bus transport sit outside this block.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A conversion accepted on clock edge E0 makes twelve bit decisions, on edges E1 to E12. `done_o` is high for exactly the one cycle that follows E12.
- R2: After the accepting edge, `trial_o` holds only its most significant bit (0x800). The search then proceeds from the MSB down to the LSB.
- R3: For each bit under trial, the bit is kept when `comp_i` is 1, meaning the input is at or above the trial level, and cleared when `comp_i` is 0. The next lower bit is set as the following trial.
- R4: When `single_ended_i` is 1, the result is straight binary clamped to 0..4095 whatever `bipolar_i` says, and `dac_bipolar_o` is 0 during the conversion.
- R5: In differential unipolar coding (`single_ended_i`=0, `bipolar_i`=0), a negative difference gives result 0, and a positive difference gives straight binary saturating at 4095.
- R6: In differential bipolar coding (`single_ended_i`=0, `bipolar_i`=1), `dac_bipolar_o` is 1, meaning trial code c stands for level c-2048. The result is the difference in 12-bit two's complement, saturating at 0x7FF and 0x800.
- R7: The mode bits are captured on the accepting edge. Changing them later in the conversion does not alter that conversion's coding.
- R8: A start request while a conversion is running is ignored: it neither restarts the search nor produces an extra `done_o` pulse.
- R9: `result_o` changes only on the edge that raises `done_o`, and holds its value between completions.
- R10: During and right after reset, `done_o`, `result_o`, `trial_o` and `dac_bipolar_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Conversion request, taken when idle |
| single_ended_i | input | 1 | 1 = input against ground, 0 = differential |
| bipolar_i | input | 1 | 1 = bipolar coding for differential inputs |
| comp_i | input | 1 | Comparator: 1 when input is at or above trial level |
| trial_o | output | 12 | Trial code to the DAC |
| dac_bipolar_o | output | 1 | Trial code is offset by half scale |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 12 | Coded conversion result |

## Verification
The first trial code, 0x800, appears one clock after the edge that accepts start. The completion pulse and the new result are due twelve clocks after that, on the thirteenth edge counted from the cycle in which start was raised. The driver records that due cycle with each expected result in a queue. The monitor samples on falling edges and compares both the arrival cycle and the coded value whenever the pulse shows. A pulse that comes early, comes late, lasts two cycles or appears with no pending item is reported as a miscompare.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int unsigned SAR_BITS = 12;

    typedef struct packed {
        logic single_ended;
        logic bipolar;
    } sar_mode_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_CONV = 1'b1
    } sar_state_e;

    // bipolar coding applies only to differential inputs
    function automatic logic bipolar_active(sar_mode_t m);
        return m.bipolar & ~m.single_ended;
    endfunction

endpackage

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             last_o,
    output logic [WIDTH-1:0] ptr_o,
    output logic             done_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    sar_state_e       state_q;
    logic [WIDTH-1:0] ptr_q;
    logic             done_q;

    assign busy_o   = (state_q == ST_CONV);
    assign accept_o = start_i & (state_q == ST_IDLE) & ~rst;
    assign last_o   = busy_o & ptr_q[0];
    assign ptr_o    = ptr_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= last_o;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept_o) begin
                        state_q <= ST_CONV;
                        ptr_q   <= TOP_BIT;
                    end
                end
                ST_CONV: begin
                    ptr_q <= ptr_q >> 1;
                    if (ptr_q[0]) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R1: exactly one bit under trial while converting
    a_r1_single_trial_bit: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ($countones(ptr_q) == 1));

    // R1: done follows the cycle in which the LSB was under trial
    a_r1_done_after_lsb: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(busy_o && ptr_q[0]));

    // R8: conversion cannot be cut short or restarted before the LSB
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !ptr_q[0]) |=> (busy_o && $countones(ptr_q) == 1 && !ptr_q[WIDTH-1]));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             busy_i,
    input  logic [WIDTH-1:0] ptr_i,
    input  logic             comp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic [WIDTH-1:0] decided_o
);

    localparam logic [WIDTH-1:0] TOP_BIT = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] trial_q;

    // resolve the bit under trial against the comparator
    assign decided_o = comp_i ? trial_q : (trial_q & ~ptr_i);
    assign trial_o   = trial_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            trial_q <= '0;
        end else if (accept_i) begin
            trial_q <= TOP_BIT;
        end else if (busy_i) begin
            trial_q <= decided_o | (ptr_i >> 1);
        end
    end

    // R2: search always begins with only the MSB set
    a_r2_msb_first: assert property (@(posedge clk) disable iff (rst)
        ($past(accept_i) && !$past(rst)) |-> (trial_q == TOP_BIT));

    // R3: a low comparator clears the bit that was under trial
    a_r3_clear_on_low: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !comp_i) |=> ((trial_q & $past(ptr_i)) == '0));

    // R3: a high comparator keeps the bit that was under trial
    a_r3_keep_on_high: assert property (@(posedge clk) disable iff (rst)
        (busy_i && comp_i) |=> ((trial_q & $past(ptr_i)) != '0));

endmodule

// File: rtl/sar_coder.sv
module sar_coder
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  logic             busy_i,
    input  logic             last_i,
    input  sar_mode_t        mode_i,
    input  logic [WIDTH-1:0] raw_i,
    output logic             dac_bipolar_o,
    output logic [WIDTH-1:0] result_o
);

    sar_mode_t        mode_q;
    logic             bip_eff;
    logic [WIDTH-1:0] coded;
    logic [WIDTH-1:0] result_q;

    assign bip_eff       = bipolar_active(mode_q);
    assign dac_bipolar_o = bip_eff;
    assign result_o      = result_q;

    // offset binary to two's complement: only the MSB is flipped
    for (genvar b = 0; b < WIDTH; b++) begin : g_code
        if (b == WIDTH - 1) begin : g_sign
            assign coded[b] = raw_i[b] ^ bip_eff;
        end else begin : g_mag
            assign coded[b] = raw_i[b];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= '0;
            result_q <= '0;
        end else begin
            if (accept_i) mode_q <= mode_i;
            if (last_i)   result_q <= coded;
        end
    end

    // R7: captured mode is frozen for the whole conversion
    a_r7_mode_frozen: assert property (@(posedge clk) disable iff (rst)
        ($past(busy_i) && busy_i) |-> $stable(mode_q));

    // R4: single-ended never runs the DAC offset
    a_r4_se_unipolar: assert property (@(posedge clk) disable iff (rst)
        mode_q.single_ended |-> !dac_bipolar_o);

    // R9: result moves only on the completing edge
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(last_i) |-> $stable(result_q));

endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
    import sar_pkg::*;
#(
    parameter int unsigned WIDTH = SAR_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             single_ended_i,
    input  logic             bipolar_i,
    input  logic             comp_i,
    output logic [WIDTH-1:0] trial_o,
    output logic             dac_bipolar_o,
    output logic             done_o,
    output logic [WIDTH-1:0] result_o
);

    logic             accept;
    logic             busy;
    logic             last;
    logic [WIDTH-1:0] ptr;
    logic [WIDTH-1:0] decided;
    sar_mode_t        mode_in;

    assign mode_in.single_ended = single_ended_i;
    assign mode_in.bipolar      = bipolar_i;

    sar_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .accept_o (accept),
        .busy_o   (busy),
        .last_o   (last),
        .ptr_o    (ptr),
        .done_o   (done_o)
    );

    sar_trial_reg #(.WIDTH(WIDTH)) u_trial (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .busy_i    (busy),
        .ptr_i     (ptr),
        .comp_i    (comp_i),
        .trial_o   (trial_o),
        .decided_o (decided)
    );

    sar_coder #(.WIDTH(WIDTH)) u_coder (
        .clk           (clk),
        .rst           (rst),
        .accept_i      (accept),
        .busy_i        (busy),
        .last_i        (last),
        .mode_i        (mode_in),
        .raw_i         (decided),
        .dac_bipolar_o (dac_bipolar_o),
        .result_o      (result_o)
    );

    // R10: outputs quiet right after reset
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!done_o && result_o == '0 && trial_o == '0 && !dac_bipolar_o));

endmodule

// File: tb/test_sar_conv_ctrl.sv
module test_sar_conv_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;

    typedef struct {
        logic [W-1:0] res;
        int           due;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         se_i = 1'b1;
    logic         bp_i = 1'b0;
    logic         comp_i;
    logic [W-1:0] trial_o;
    logic         dac_bipolar_o;
    logic         done_o;
    logic [W-1:0] result_o;

    int   vin = 0;
    int   cyc = 0;
    int   checks = 0;
    int   fails = 0;
    int   stab_err = 0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // behavioural comparator: trial level is offset by half scale in bipolar coding
    assign comp_i = (vin >= (dac_bipolar_o ? (int'(trial_o) - 2048) : int'(trial_o)));

    sar_conv_ctrl i_sar_conv_ctrl (
        .clk            (clk),
        .rst            (rst),
        .start_i        (start_i),
        .single_ended_i (se_i),
        .bipolar_i      (bp_i),
        .comp_i         (comp_i),
        .trial_o        (trial_o),
        .dac_bipolar_o  (dac_bipolar_o),
        .done_o         (done_o),
        .result_o       (result_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] expect_code(int v, bit se, bit bp);
        int c;
        if (!se && bp) begin
            c = (v > 2047) ? 2047 : ((v < -2048) ? -2048 : v);
        end else begin
            c = (v > 4095) ? 4095 : ((v < 0) ? 0 : v);
        end
        return c[W-1:0];
    endfunction

    // mode: 0 plain, 1 change mode bits after accept (R7), 2 extra start mid-run (R8)
    task automatic convert(int v, bit se, bit bp, int variant, string tag);
        exp_t e;
        @(negedge clk);
        vin = v; se_i = se; bp_i = bp; start_i = 1'b1;
        e.res = expect_code(v, se, bp);
        e.due = cyc + 13;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        chk({"R2 first trial ", tag}, int'(trial_o), 32'h800);
        chk({"R4/R6 dac offset ", tag}, int'(dac_bipolar_o), int'(bp & ~se));
        if (variant == 1) begin
            se_i = ~se; bp_i = ~bp;
        end
        repeat (4) @(negedge clk);
        if (variant == 2) begin
            start_i = 1'b1; se_i = ~se;
            @(negedge clk);
            start_i = 1'b0;
            repeat (7) @(negedge clk);
        end else begin
            repeat (8) @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    // monitor / scoreboard
    logic [W-1:0] prev_res;
    bit           prev_ok = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (done_o) begin
                if (sb.size() == 0) begin
                    chk("R8 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk({"R1 done cycle ", e.tag}, cyc, e.due);
                    chk({"R3-coded result ", e.tag}, int'(result_o), int'(e.res));
                end
            end else if (prev_ok && result_o !== prev_res) begin
                stab_err++;
            end
            prev_res = result_o;
            prev_ok  = 1'b1;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R10 done in reset", int'(done_o), 0);
        chk("R10 result in reset", int'(result_o), 0);
        chk("R10 trial in reset", int'(trial_o), 0);
        chk("R10 dac offset in reset", int'(dac_bipolar_o), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 done after reset", int'(done_o), 0);

        // R4 single-ended
        convert(0,    1, 0, 0, "R4 se zero");
        convert(4095, 1, 0, 0, "R4 se full");
        convert(1234, 1, 0, 0, "R4 se mid");
        convert(3000, 1, 1, 0, "R4 se bip ignored");
        convert(2048, 1, 1, 0, "R4 se half");
        // R5 differential unipolar
        convert(-5,   0, 0, 0, "R5 neg clamp");
        convert(777,  0, 0, 0, "R5 mid");
        convert(5000, 0, 0, 0, "R5 over");
        convert(4095, 0, 0, 0, "R5 full");
        // R6 differential bipolar
        convert(-2048, 0, 1, 0, "R6 min");
        convert(2047,  0, 1, 0, "R6 max");
        convert(-1,    0, 1, 0, "R6 minus one");
        convert(0,     0, 1, 0, "R6 zero");
        convert(-300,  0, 1, 0, "R6 neg");
        convert(5000,  0, 1, 0, "R6 sat pos");
        convert(-9000, 0, 1, 0, "R6 sat neg");
        // R7 mode changed mid-conversion
        convert(-100, 0, 1, 1, "R7 bip then se");
        convert(-100, 0, 0, 1, "R7 uni then bip");
        // R8 start while busy
        convert(1500, 0, 1, 2, "R8 restart ignored");
        convert(321,  1, 0, 2, "R8 restart ignored se");

        repeat (20) @(negedge clk);
        chk("R8 no pending results", sb.size(), 0);
        chk("R9 result held between completions", stab_err, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule